// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reload

The block is a watchdog built around a 24-bit down-counter. It sits on a small byte-wide register bus with four locations. Location 0 holds the control and status byte. Locations 1, 2 and 3 hold the upper, middle and low bytes of the 24-bit reload value. Software enables the watchdog through the control byte and must then keep refreshing it. If it fails to do so, the counter runs out and the block issues either a system-reset request or, while the device sleeps in stop mode, a stop-recovery request.

Stray writes must not be able to shorten or stretch the time-out period. For this reason the reload bytes are guarded by a key sequence. Two key bytes go to the control location, and then the three reload bytes are written in a fixed order. Any other write in between relocks the reload bytes. The counter only advances on cycles where the external tick enable is high, so any slower watchdog clock appears to the block as a one-cycle enable.

Top module: `wdog_guard`

## Requirements
- R1: Control byte layout is bit 0 enable, bit 1 reset-on-time-out select, bit 6 stop flag, bit 7 time-out flag, with the other bits reading 0. After reset it reads 02h and the reload value is 000400h. A write of 55h or AAh to address 0 changes no control bit; any other value written there loads bits 0 and 1.
- R2: After 55h and then AAh are written to address 0, writes to address 1 (upper), address 2 (middle) and address 3 (low), in that order, store their data in the reload bytes. Reads of addresses 1 to 3 return the stored bytes.
- R3: A write to a reload address made while locked or out of order leaves that byte unchanged. Any write other than the next one expected returns the guard to locked. A 55h written to address 0 always restarts the sequence.
- R4: Once the low byte has been written, the guard is locked again, and further reload writes are ignored until a new 55h/AAh.
- R5: The counter takes the reload value on the edge of a control write that turns enable from 0 to 1, and on any refresh pulse while enabled. A refresh while disabled does nothing. A refresh on the same cycle as a tick takes priority, and that tick does not count.
- R6: While enabled, each tick lowers the counter by one. With reload N ≥ 1, the N-th tick after a load is a time-out, and a reload of 0 behaves like 1. On a time-out the counter reloads and keeps running.
- R7: On a time-out with reset select set and stop mode low, `rstReq` is high for exactly the one cycle after that tick's edge, and bit 7 is set.
- R8: On a time-out with reset select set and stop mode high, `smrReq` pulses instead of `rstReq`, and bits 7 and 6 are both set.
- R9: A read of address 0 returns the flags and then clears bits 7 and 6 at that edge; a time-out on the same cycle wins. Reload writes never touch the flags. `rdata` is combinational and is 0 when `rdEn` is low.
- R10: With reset select clear, a time-out raises no request and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| tickEn | input | 1 | Watchdog count enable |
| refresh | input | 1 | Refresh pulse |
| stopMode | input | 1 | Device is in stop mode |
| rstReq | output | 1 | System-reset request pulse |
| smrReq | output | 1 | Stop-recovery request pulse |

## Verification
Read data depends only on the current state, so the bench checks it 1 ns after driving a read, before the clock edge. Register writes, flag clears and counter loads all take effect at the next edge. The request pulses are registered, so they are due in the cycle that follows the tick which expired the counter. The bench therefore checks them at the falling edge after that rising edge, and checks them again one cycle later to see them fall. A reference model moves forward in step with every clock edge, so each of these comparisons is made exactly in the cycle its result is due.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int NBYTES    = 3;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_UP   = 1;
  localparam int ADDR_MID  = 2;
  localparam int ADDR_LOW  = 3;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_KEY1,
    LK_OPEN,
    LK_MID,
    LK_LAST
  } lockState_t;

  typedef struct packed {
    logic [NBYTES-1:0] byteWr;
    logic              loadCount;
    logic              countStep;
  } dpStrobe_t;
endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [NBYTES*BYTE_W-1:0] RELOAD_INIT = 'h000400
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strb,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [NBYTES*BYTE_W-1:0] reloadVal,
  output logic                     expire
);
  localparam int CNT_W = NBYTES * BYTE_W;

  logic [BYTE_W-1:0] relByte [NBYTES];
  logic [CNT_W-1:0]  cnt;
  logic              nearZero;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               relByte[b] <= RELOAD_INIT[b*BYTE_W +: BYTE_W];
      else if (strb.byteWr[b]) relByte[b] <= wdata;
    end
    assign reloadVal[b*BYTE_W +: BYTE_W] = relByte[b];
  end

  assign nearZero = (cnt[CNT_W-1:1] == '0);
  assign expire   = strb.countStep && !strb.loadCount && nearZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strb.loadCount) cnt <= reloadVal;
    else if (strb.countStep) cnt <= expire ? reloadVal : cnt - 1'b1;
  end

  AST_LOAD_TAKES_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> cnt == $past(reloadVal)); // R5
  AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteWr == '0) |=> $stable(reloadVal)); // R3
  AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> cnt == $past(reloadVal)); // R6
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [BYTE_W-1:0] KEY_A = 8'h55,
  parameter logic [BYTE_W-1:0] KEY_B = 8'hAA
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W-1:0]        wdata,
  input  logic                     tickEn,
  input  logic                     refresh,
  input  logic                     stopMode,
  input  logic                     expire,
  input  logic [NBYTES*BYTE_W-1:0] reloadVal,
  output dpStrobe_t                strb,
  output logic [BYTE_W-1:0]        rdata,
  output logic                     rstReq,
  output logic                     smrReq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(ADDR_UP);
  localparam logic [ADDR_W-1:0] A_MID  = ADDR_W'(ADDR_MID);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(ADDR_LOW);

  lockState_t lockState, lockNext;
  logic enable, resetSel, wdtFlag, stopFlag;
  logic ctrlWr, isKey, keyStart, enRise, hit, clearRd;

  assign ctrlWr   = wrEn && (addr == A_CTRL);
  assign isKey    = (wdata == KEY_A) || (wdata == KEY_B);
  assign keyStart = ctrlWr && (wdata == KEY_A);
  assign enRise   = ctrlWr && !isKey && wdata[0] && !enable;
  assign clearRd  = rdEn && (addr == A_CTRL);
  assign hit      = expire && resetSel;

  // guard state machine: only writes move it
  always_comb begin
    lockNext = lockState;
    if (wrEn) begin
      if (keyStart) lockNext = LK_KEY1;
      else begin
        unique case (lockState)
          LK_KEY1: lockNext = (ctrlWr && wdata == KEY_B) ? LK_OPEN : LK_IDLE;
          LK_OPEN: lockNext = (addr == A_UP)  ? LK_MID  : LK_IDLE;
          LK_MID:  lockNext = (addr == A_MID) ? LK_LAST : LK_IDLE;
          default: lockNext = LK_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockState <= LK_IDLE;
    else       lockState <= lockNext;
  end

  always_comb begin
    strb           = '0;
    strb.byteWr[2] = wrEn && (lockState == LK_OPEN) && (addr == A_UP);
    strb.byteWr[1] = wrEn && (lockState == LK_MID)  && (addr == A_MID);
    strb.byteWr[0] = wrEn && (lockState == LK_LAST) && (addr == A_LOW);
    strb.loadCount = enRise || (refresh && enable);
    strb.countStep = enable && tickEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      resetSel <= 1'b1;
    end else if (ctrlWr && !isKey) begin
      enable   <= wdata[0];
      resetSel <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtFlag  <= 1'b0;
      stopFlag <= 1'b0;
      rstReq   <= 1'b0;
      smrReq   <= 1'b0;
    end else begin
      rstReq <= hit && !stopMode;
      smrReq <= hit && stopMode;
      if (hit)          wdtFlag <= 1'b1;
      else if (clearRd) wdtFlag <= 1'b0;
      if (hit && stopMode) stopFlag <= 1'b1;
      else if (clearRd)    stopFlag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      if      (addr == A_CTRL) rdata = {wdtFlag, stopFlag, (BYTE_W-4)'(0), resetSel, enable};
      else if (addr == A_UP)   rdata = reloadVal[2*BYTE_W +: BYTE_W];
      else if (addr == A_MID)  rdata = reloadVal[BYTE_W +: BYTE_W];
      else if (addr == A_LOW)  rdata = reloadVal[0 +: BYTE_W];
    end
  end

  AST_KEY_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && isKey) |=> ($stable(enable) && $stable(resetSel))); // R1
  AST_SEQ_RELOCK: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_LAST && wrEn && !keyStart) |=> lockState == LK_IDLE); // R4
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rstReq && smrReq)); // R8
  AST_RST_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> wdtFlag); // R7
  AST_SMR_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    smrReq |-> (wdtFlag && stopFlag)); // R8
  AST_NO_REQ_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !resetSel) |=> !(rstReq || smrReq)); // R10
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [BYTE_W-1:0] KEY_A = 8'h55,
  parameter logic [BYTE_W-1:0] KEY_B = 8'hAA,
  parameter logic [NBYTES*BYTE_W-1:0] RELOAD_INIT = 'h000400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              tickEn,
  input  logic              refresh,
  input  logic              stopMode,
  output logic              rstReq,
  output logic              smrReq
);
  dpStrobe_t                strb;
  logic [NBYTES*BYTE_W-1:0] reloadVal;
  logic                     expire;

  wdg_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .tickEn(tickEn), .refresh(refresh), .stopMode(stopMode), .expire(expire),
    .reloadVal(reloadVal), .strb(strb), .rdata(rdata), .rstReq(rstReq), .smrReq(smrReq)
  );

  wdg_datapath #(.BYTE_W(BYTE_W), .RELOAD_INIT(RELOAD_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata),
    .reloadVal(reloadVal), .expire(expire)
  );
endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, wrEn, rdEn, tickEn, refresh, stopMode;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       rstReq, smrReq;

  wdog_guard u_wdog_guard (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tickEn(tickEn), .refresh(refresh), .stopMode(stopMode),
    .rstReq(rstReq), .smrReq(smrReq)
  );

  int errs = 0;
  int checks = 0;

  // reference model state
  int          mSt;
  bit          mEn, mRsel, mWdt, mStp, mRst, mSmr, stopIn;
  logic [23:0] mRel, mCnt;

  function automatic logic [7:0] modelRead(logic [1:0] a);
    case (a)
      2'd0:    return {mWdt, mStp, 4'b0, mRsel, mEn};
      2'd1:    return mRel[23:16];
      2'd2:    return mRel[15:8];
      default: return mRel[7:0];
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit w, bit r, logic [1:0] a, logic [7:0] d, bit tk, bit rf);
    bit isC, isKey, enRise, load, tmo, hit;
    int nSt;
    logic [23:0] nRel, nCnt;
    bit nEn, nRsel, nWdt, nStp;
    wrEn = w; rdEn = r; addr = a; wdata = d; tickEn = tk; refresh = rf; stopMode = stopIn;
    #1;
    if (r) check((a == 2'd0) ? "R9" : "R2", rdata, modelRead(a));
    isC    = w && (a == 2'd0);
    isKey  = (d == 8'h55) || (d == 8'hAA);
    enRise = isC && !isKey && d[0] && !mEn;
    load   = enRise || (rf && mEn);
    tmo    = !load && mEn && tk && (mCnt <= 24'd1);
    hit    = tmo && mRsel;
    nSt = mSt; nRel = mRel; nCnt = mCnt; nEn = mEn; nRsel = mRsel;
    if (w) begin
      if (isC && d == 8'h55) nSt = 1;
      else begin
        case (mSt)
          1: nSt = (isC && d == 8'hAA) ? 2 : 0;
          2: if (a == 2'd1) begin nRel[23:16] = d; nSt = 3; end else nSt = 0;
          3: if (a == 2'd2) begin nRel[15:8] = d; nSt = 4; end else nSt = 0;
          4: begin if (a == 2'd3) nRel[7:0] = d; nSt = 0; end
          default: nSt = 0;
        endcase
      end
    end
    if (load) nCnt = mRel;
    else if (mEn && tk) nCnt = tmo ? mRel : mCnt - 24'd1;
    if (isC && !isKey) begin nEn = d[0]; nRsel = d[1]; end
    nWdt = hit ? 1'b1 : ((r && a == 2'd0) ? 1'b0 : mWdt);
    nStp = (hit && stopIn) ? 1'b1 : ((r && a == 2'd0) ? 1'b0 : mStp);
    @(posedge clk);
    mSt = nSt; mRel = nRel; mCnt = nCnt; mEn = nEn; mRsel = nRsel;
    mWdt = nWdt; mStp = nStp; mRst = hit && !stopIn; mSmr = hit && stopIn;
    @(negedge clk);
    check("R7", rstReq, mRst);
    check("R8", smrReq, mSmr);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0);
  endtask

  task automatic readCheck(logic [1:0] a, logic [7:0] exp, string req);
    wrEn = 1'b0; rdEn = 1'b1; addr = a; tickEn = 1'b0; refresh = 1'b0;
    #1;
    check(req, rdata, exp);
    step(1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int seedDummy;
    bit w, r, tk, rf;
    logic [1:0] a;
    logic [7:0] d;
    seedDummy = $urandom(32'd4711);
    rstN = 1'b0; wrEn = 0; rdEn = 0; addr = 0; wdata = 0; tickEn = 0; refresh = 0; stopMode = 0;
    stopIn = 0; mSt = 0; mEn = 0; mRsel = 1; mWdt = 0; mStp = 0; mRst = 0; mSmr = 0;
    mRel = 24'h000400; mCnt = 24'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readCheck(2'd0, 8'h02, "R1");
    readCheck(2'd2, 8'h04, "R1");
    // R3 locked write ignored
    wr(2'd1, 8'h11);
    readCheck(2'd1, 8'h00, "R3");
    // R1 keys leave control untouched, R2 full sequence
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h05);
    readCheck(2'd0, 8'h02, "R1");
    readCheck(2'd3, 8'h05, "R2");
    readCheck(2'd2, 8'h00, "R2");
    // R4 relocked after low byte
    wr(2'd3, 8'h07);
    readCheck(2'd3, 8'h05, "R4");
    // R3 out of order
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd2, 8'h09); wr(2'd1, 8'h09);
    readCheck(2'd2, 8'h00, "R3");
    readCheck(2'd1, 8'h00, "R3");
    // R3 intervening write
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h02); wr(2'd1, 8'h33);
    readCheck(2'd1, 8'h00, "R3");
    // R5/R6/R7 enable and run to time-out at tick 5
    wr(2'd0, 8'h03);
    ticks(4);
    check("R6", rstReq, 1'b0);
    ticks(1);
    check("R6", rstReq, 1'b1);
    readCheck(2'd0, 8'h83, "R7");
    readCheck(2'd0, 8'h03, "R9");
    // R5 refresh restarts the count
    ticks(3);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
    ticks(4);
    check("R5", rstReq, 1'b0);
    ticks(1);
    check("R5", rstReq, 1'b1);
    // R8 stop mode
    stopIn = 1;
    ticks(5);
    check("R8", smrReq, 1'b1);
    check("R8", rstReq, 1'b0);
    stopIn = 0;
    readCheck(2'd0, 8'hC3, "R8");
    // R10 reset select cleared
    wr(2'd0, 8'h01);
    ticks(5);
    check("R10", rstReq, 1'b0);
    readCheck(2'd0, 8'h01, "R10");
    // R5 refresh while disabled
    wr(2'd0, 8'h02);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
    ticks(10);
    readCheck(2'd0, 8'h02, "R5");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 60 == 0) stopIn = !stopIn;
      w  = ($urandom % 5 == 0);
      r  = ($urandom % 5 == 0);
      a  = 2'($urandom % 4);
      tk = ($urandom % 2 == 0);
      rf = ($urandom % 25 == 0);
      case ($urandom % 8)
        0: d = 8'h55;
        1: d = 8'hAA;
        2: d = 8'h03;
        3: d = 8'h02;
        4: d = 8'h01;
        default: d = (a == 2'd3) ? 8'($urandom % 12) : ((a == 2'd0) ? 8'($urandom) : 8'h00);
      endcase
      step(w, r, a, d, tk, rf);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule